// File: doc/BRIEF.md
# Buck Gate-Drive Sequencing Controller

This block is a synchronous controller for the two gate commands of a synchronous buck power stage. One command drives the high-side switch and the other drives the low-side switch. It takes a pre-decoded three-level PWM command, an enable input and an undervoltage flag. It also takes comparator feedback saying that each gate has dropped below its turn-off threshold, and a zero-current comparator flag from the switch node. From these it produces the two gate commands and a pull-down request for the shared enable line.

PWM high turns on the high side and PWM low turns on the low side. A mid level selects diode emulation. In that mode the low side conducts until the inductor current reaches zero, and then both switches stay off. Dead time is adaptive. The gate being released must first be commanded off and reported low by its feedback comparator. Only then does a fixed turn-on delay of `DEAD_CYC` cycles run before the other gate may rise. In diode emulation the zero-current flag is blanked for `BLANK_CYC` cycles after the low side turns on. It must then stay high for `DEB_CYC` consecutive cycles before the low side is released. All delays are derived from nanosecond parameters and the clock frequency `CLK_MHZ`. At the defaults (125 MHz, 16/250/80 ns) they come to 2, 32 and 10 cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is active and right after it, both gate commands and the fault pull-down are low.
- R2: With PWM code 2'b10 (high) held, enable high and undervoltage low, the steady state is high-side on and low-side off.
- R3: With PWM code 2'b00 (low) held, the steady state is low-side on and high-side off, and the zero-current flag has no effect.
- R4: The two gate commands are never high in the same cycle, including when the PWM code changes in the middle of a sequence.
- R5: The high-side command rises only when, in the previous cycle, the low-side command was low and its low feedback was high. With feedback that follows at once, the high side rises exactly `DEAD_CYC` cycles after the low side falls. With feedback stuck not-low, the high side never rises.
- R6: The low-side command rises only when, in the previous cycle, the high-side command was low and its low feedback was high. With feedback that follows at once, the low side rises exactly `DEAD_CYC` cycles after the high side falls.
- R7: PWM code 2'b01 (mid) with the zero-current flag low gives low-side on and high-side off.
- R8: In mid mode the zero-current flag is ignored during the first `BLANK_CYC` cycles of low-side conduction. After that it must stay high for `DEB_CYC` consecutive cycles, and then the low side turns off. A shorter pulse has no effect. Entered with the flag already high, the low side falls between `BLANK_CYC+DEB_CYC` and `BLANK_CYC+DEB_CYC+4` cycles after the code changes.
- R9: PWM code 2'b11 (invalid) behaves exactly like mid mode.
- R10: Enable low forces both gate commands low from the next cycle and makes the PWM code ignored.
- R11: Undervoltage forces both gate commands low from the next cycle and raises the fault pull-down from the next cycle. The pull-down drops the cycle after undervoltage clears.
- R12: The zero-current latch clears when PWM leaves mid, so a later return to mid turns the low side on again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_code | input | 2 | Three-level PWM command: 00 low, 01 mid, 10 high, 11 treated as mid |
| drv_en | input | 1 | Enable; low forces both gates off |
| uv_flag | input | 1 | Supply undervoltage comparator output |
| hs_low_fb | input | 1 | High-side gate is below its turn-off threshold |
| ls_low_fb | input | 1 | Low-side gate is below its turn-off threshold |
| zc_flag | input | 1 | Zero-current comparator on the switch node |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |
| en_pull_dn | output | 1 | Request to pull the shared enable line low on a fault |

## Verification
The assertions check four things on every cycle: that the two gates never overlap, that each gate rises only after the opposite gate was commanded off and reported low, that undervoltage or disable clears both gates on the next cycle, and that the pull-down follows undervoltage. The exact dead-time count, the blanking and debounce windows, the rejection of short zero-current pulses, the treatment of the invalid code and the clearing of the zero-current latch on leaving mid cannot be shown cycle by cycle. Only the bench's timed scenarios can show them.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;

    typedef enum logic [1:0] {
        PWM_LO  = 2'd0,
        PWM_MID = 2'd1,
        PWM_HI  = 2'd2
    } pwm_mode_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HS   = 2'd1,
        TGT_LS   = 2'd2
    } gate_tgt_e;

    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bgs_decode.sv
module bgs_decode
    import buck_gate_pkg::*;
(
    input  logic [1:0] code,
    output pwm_mode_e  mode
);
    always_comb begin
        unique case (code)
            2'b00:   mode = PWM_LO;
            2'b10:   mode = PWM_HI;
            default: mode = PWM_MID;
        endcase
    end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import buck_gate_pkg::*;
#(
    parameter int CLK_MHZ     = 125,
    parameter int DEAD_NS     = 16,
    parameter int BLANK_NS    = 250,
    parameter int DEB_NS      = 80,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    input  logic       drv_en,
    input  logic       uv_flag,
    input  logic       hs_low_fb,
    input  logic       ls_low_fb,
    input  logic       zc_flag,
    output logic       hs_on,
    output logic       ls_on,
    output logic       en_pull_dn
);
    localparam int DEAD_CYC  = ns_to_cyc(DEAD_NS, CLK_MHZ);
    localparam int BLANK_CYC = ns_to_cyc(BLANK_NS, CLK_MHZ);
    localparam int DEB_CYC   = ns_to_cyc(DEB_NS, CLK_MHZ);
    localparam int DT_W      = $clog2(DEAD_CYC + 1);
    localparam int BT_W      = $clog2(BLANK_CYC + 1);
    localparam int DB_W      = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic            hs;
        logic            ls;
        logic            pd;
        logic            zl;
        gate_tgt_e       tgt;
        logic [DT_W-1:0] dt;
        logic [BT_W-1:0] bt;
        logic [DB_W-1:0] db;
    } seq_st_t;

    seq_st_t   st_d, st_q;
    logic [1:0] pwm_sync;
    pwm_mode_e  mode;

    bgs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwm_code),
        .dout (pwm_sync)
    );

    bgs_decode u_dec (
        .code(pwm_sync),
        .mode(mode)
    );

    always_comb begin
        gate_tgt_e tgt;
        logic      zl_n;
        logic      qual;
        st_d    = st_q;
        st_d.pd = uv_flag;
        tgt     = TGT_NONE;
        zl_n    = 1'b0;
        qual    = 1'b0;
        if (uv_flag || !drv_en) begin
            st_d.hs  = 1'b0;
            st_d.ls  = 1'b0;
            st_d.zl  = 1'b0;
            st_d.tgt = TGT_NONE;
            st_d.dt  = '0;
            st_d.bt  = '0;
            st_d.db  = '0;
        end else begin
            // zero-current detection: blanking, then debounce
            zl_n = (mode == PWM_MID) ? st_q.zl : 1'b0;
            if (mode == PWM_MID && st_q.ls && !st_q.zl) begin
                if (st_q.bt < BT_W'(BLANK_CYC)) begin
                    st_d.bt = st_q.bt + 1'b1;
                    st_d.db = '0;
                end else if (zc_flag) begin
                    if (st_q.db >= DB_W'(DEB_CYC - 1)) begin
                        zl_n    = 1'b1;
                        st_d.db = '0;
                    end else begin
                        st_d.db = st_q.db + 1'b1;
                    end
                end else begin
                    st_d.db = '0;
                end
            end else begin
                st_d.bt = '0;
                st_d.db = '0;
            end
            st_d.zl = zl_n;

            unique case (mode)
                PWM_HI:  tgt = TGT_HS;
                PWM_LO:  tgt = TGT_LS;
                default: tgt = zl_n ? TGT_NONE : TGT_LS;
            endcase
            st_d.tgt = tgt;

            // adaptive dead time toward the wanted gate
            unique case (tgt)
                TGT_HS: begin
                    st_d.ls = 1'b0;
                    qual    = !st_q.ls && ls_low_fb && !st_q.hs && (tgt == st_q.tgt);
                end
                TGT_LS: begin
                    st_d.hs = 1'b0;
                    qual    = !st_q.hs && hs_low_fb && !st_q.ls && (tgt == st_q.tgt);
                end
                default: begin
                    st_d.hs = 1'b0;
                    st_d.ls = 1'b0;
                end
            endcase

            if (!qual) begin
                st_d.dt = '0;
            end else if (st_q.dt >= DT_W'(DEAD_CYC - 1)) begin
                st_d.dt = '0;
                if (tgt == TGT_HS) st_d.hs = 1'b1;
                else               st_d.ls = 1'b1;
            end else begin
                st_d.dt = st_q.dt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hs: 1'b0, ls: 1'b0, pd: 1'b0, zl: 1'b0, tgt: TGT_NONE,
                      dt: '0, bt: '0, db: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_on      = st_q.hs;
    assign ls_on      = st_q.ls;
    assign en_pull_dn = st_q.pd;
endmodule

// File: rtl/bgs_chk.sv
module bgs_chk (
    input logic clk,
    input logic rst_n,
    input logic drv_en,
    input logic uv_flag,
    input logic hs_low_fb,
    input logic ls_low_fb,
    input logic hs_on,
    input logic ls_on,
    input logic en_pull_dn
);
    // R4
    gate_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R5
    hs_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(!ls_on && ls_low_fb));

    // R6
    ls_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> $past(!hs_on && hs_low_fb));

    // R10
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> (!hs_on && !ls_on));

    // R11
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (!hs_on && !ls_on));

    // R11
    uv_pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> en_pull_dn);

    // R11
    pulldown_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_flag |=> !en_pull_dn);
endmodule

bind buck_gate_seq bgs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_en    (drv_en),
    .uv_flag   (uv_flag),
    .hs_low_fb (hs_low_fb),
    .ls_low_fb (ls_low_fb),
    .hs_on     (hs_on),
    .ls_on     (ls_on),
    .en_pull_dn(en_pull_dn)
);

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
    localparam int DEAD_E  = 2;   // ceil(16 ns * 125 MHz)
    localparam int BLANK_E = 32;  // ceil(250 ns * 125 MHz)
    localparam int DEB_E   = 10;  // ceil(80 ns * 125 MHz)

    typedef struct packed {
        logic [1:0] pwm;
        logic       en;
        logic       uv;
        logic       zc;
        logic       hs;
        logic       ls;
        logic       pd;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},   // R2 high
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // R3 low
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7},   // R7 mid
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 zero current
        '{2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},   // R3 zc ignored
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd12},  // R12 latch cleared
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},   // R9 invalid as mid
        '{2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},   // R9 invalid zc
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10},  // R10 disabled
        '{2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11},  // R11 undervoltage
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},   // R2 recovery
        '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd11}   // R11 with disable
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_code = 2'b00;
    logic       drv_en = 1'b0;
    logic       uv_flag = 1'b0;
    logic       zc_flag = 1'b0;
    logic       stuck_hs = 1'b0;
    logic       stuck_ls = 1'b0;
    logic       hs_low_fb, ls_low_fb;
    logic       hs_on, ls_on, en_pull_dn;
    int         n_chk = 0;
    int         n_bad = 0;
    int         overlap_seen = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign hs_low_fb = stuck_hs ? 1'b0 : !hs_on;
    assign ls_low_fb = stuck_ls ? 1'b0 : !ls_on;

    buck_gate_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_code  (pwm_code),
        .drv_en    (drv_en),
        .uv_flag   (uv_flag),
        .hs_low_fb (hs_low_fb),
        .ls_low_fb (ls_low_fb),
        .zc_flag   (zc_flag),
        .hs_on     (hs_on),
        .ls_on     (ls_on),
        .en_pull_dn(en_pull_dn)
    );

    // R4 invariant sampled on every cycle
    always @(negedge clk) if (hs_on && ls_on) overlap_seen++;

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // cycles from now until sig reaches val, bounded
    task automatic wait_for(input bit use_hs, input logic val, output int n);
        n = 0;
        while (((use_hs ? hs_on : ls_on) !== val) && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int g;
        int t;
        // R1 reset state
        cyc(3);
        chk(1, "hs in reset", hs_on, 0);
        chk(1, "ls in reset", ls_on, 0);
        chk(1, "pd in reset", en_pull_dn, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(1, "hs after reset", hs_on, 0);
        drv_en = 1'b1;

        for (int v = 0; v < NV; v++) begin
            pwm_code = VECS[v].pwm;
            drv_en   = VECS[v].en;
            uv_flag  = VECS[v].uv;
            zc_flag  = VECS[v].zc;
            cyc(60);
            chk(VECS[v].req, $sformatf("vec%0d hs", v), hs_on, VECS[v].hs);
            chk(VECS[v].req, $sformatf("vec%0d ls", v), ls_on, VECS[v].ls);
            chk(VECS[v].req, $sformatf("vec%0d pd", v), en_pull_dn, VECS[v].pd);
        end

        drv_en = 1'b1; uv_flag = 1'b0; zc_flag = 1'b0;
        pwm_code = 2'b00;
        cyc(20);

        // R5 exact dead time low -> high
        pwm_code = 2'b10;
        wait_for(1'b0, 1'b0, t);
        wait_for(1'b1, 1'b1, g);
        chk(5, "hs rise after ls fall", g, DEAD_E);

        // R6 exact dead time high -> low
        pwm_code = 2'b00;
        wait_for(1'b1, 1'b0, t);
        wait_for(1'b0, 1'b1, g);
        chk(6, "ls rise after hs fall", g, DEAD_E);

        // R5 stuck low-side feedback blocks high side
        cyc(10);
        stuck_ls = 1'b1;
        pwm_code = 2'b10;
        cyc(30);
        chk(5, "hs with stuck ls feedback", hs_on, 0);
        chk(5, "ls off while waiting", ls_on, 0);
        stuck_ls = 1'b0;
        cyc(5);
        chk(5, "hs after feedback release", hs_on, 1);

        // R6 stuck high-side feedback blocks low side
        stuck_hs = 1'b1;
        pwm_code = 2'b00;
        cyc(30);
        chk(6, "ls with stuck hs feedback", ls_on, 0);
        stuck_hs = 1'b0;
        cyc(5);
        chk(6, "ls after feedback release", ls_on, 1);

        // R8 blanking: enter mid with zc already high
        cyc(10);
        zc_flag  = 1'b1;
        pwm_code = 2'b01;
        wait_for(1'b0, 1'b0, g);
        chk(8, "blank+debounce lower bound", int'(g >= BLANK_E + DEB_E), 1);
        chk(8, "blank+debounce upper bound", int'(g <= BLANK_E + DEB_E + 4), 1);

        // R12 leave mid then return: ls on again
        zc_flag  = 1'b0;
        pwm_code = 2'b00;
        cyc(10);
        pwm_code = 2'b01;
        cyc(10);
        chk(12, "ls after return to mid", ls_on, 1);

        // R8 short pulse after blanking is rejected
        cyc(BLANK_E + 5);
        zc_flag = 1'b1;
        cyc(DEB_E - 2);
        zc_flag = 1'b0;
        cyc(10);
        chk(8, "ls after short zc pulse", ls_on, 1);
        zc_flag = 1'b1;
        cyc(DEB_E + 4);
        chk(8, "ls after held zc", ls_on, 0);
        zc_flag = 1'b0;

        // R4 rapid PWM changes mid-sequence
        pwm_code = 2'b00;
        cyc(10);
        for (int k = 0; k < 20; k++) begin
            pwm_code = (k % 2 == 0) ? 2'b10 : 2'b00;
            cyc(1 + (k % 4));
        end
        pwm_code = 2'b10;
        cyc(20);
        chk(4, "hs settles after toggling", hs_on, 1);
        chk(4, "overlap cycles seen", overlap_seen, 0);

        // R10 disable mid-conduction: off on the next cycle
        drv_en = 1'b0;
        cyc(1);
        chk(10, "hs one cycle after disable", hs_on, 0);
        drv_en = 1'b1;
        cyc(10);

        // R11 undervoltage: off and pull-down next cycle, release next cycle
        uv_flag = 1'b1;
        cyc(1);
        chk(11, "hs one cycle after uv", hs_on, 0);
        chk(11, "pd one cycle after uv", en_pull_dn, 1);
        uv_flag = 1'b0;
        cyc(1);
        chk(11, "pd one cycle after uv clear", en_pull_dn, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule